// File: doc/BRIEF.md
# Program Counter and Next-Fetch-Address Unit

This block holds the program counter of a processor that completes one instruction per clock, and on every rising edge loads the address of the next instruction to fetch. Control logic elsewhere decodes the instruction and presents a two-bit select code. The code chooses one of four sources: the sequential successor, a PC-relative branch target, a region-local jump target, or an address read from a register for indirect jumps. The block computes each of these targets with its own dedicated logic. It does not borrow the ALU, which is busy comparing operands during a branch.

A parameter selects one of two variants. The basic variant restarts at address zero and ignores the exception inputs. The extended variant restarts at a high boot address and redirects fetch to fixed handler addresses when an interrupt or an illegal opcode is signalled. In that case it also asks the register file to save the return address, PC+4, into register 27. The block always drives PC+4 so that link writes for call instructions can use it.

Top module: `fetch_addr_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the PC with the reset address: 0x00000000 in the basic variant (`EXT_MODE`=0) and 0x80000000 in the extended variant (`EXT_MODE`=1).
- R2: With `pc_sel`=2'b00 and no exception taken, the next PC is the current PC plus 4.
- R3: `pc_plus4` always equals the current PC plus 4, modulo 2^32, in the same cycle.
- R4: With `pc_sel`=2'b01, the next PC is PC + 4 + (instr[15:0] sign-extended to 32 bits and shifted left by 2). Negative offsets move backwards.
- R5: With `pc_sel`=2'b10, the next PC is {PC[31:28], instr[25:0], 2'b00}. The top four bits come from the current PC, not from PC+4.
- R6: With `pc_sel`=2'b11, the next PC is `reg_target` with its two low bits forced to zero.
- R7: In the extended variant, `bad_op` high without `irq` loads the PC with 0x80000040. In that cycle `link_we` is high and `link_idx` is 27.
- R8: In the extended variant, `irq` high loads the PC with 0x80000080 and raises `link_we` with `link_idx`=27. It takes precedence over both `bad_op` and `pc_sel`.
- R9: Reset takes precedence over `irq` and `bad_op`. `link_we` is low in any cycle where `rst` is high.
- R10: In the basic variant, `irq` and `bad_op` have no effect: the PC follows `pc_sel` and `link_we` stays low.
- R11: After reset, the two low bits of the PC are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Current instruction word (offset and jump index fields) |
| pc_sel | input | 2 | Next-address source: 00 sequential, 01 branch, 10 jump, 11 register |
| reg_target | input | 32 | Register value for indirect jumps |
| irq | input | 1 | Interrupt request (extended variant only) |
| bad_op | input | 1 | Illegal-opcode indication (extended variant only) |
| pc | output | 32 | Current program counter / fetch address |
| pc_plus4 | output | 32 | PC+4, for link writes |
| link_we | output | 1 | Request to write `pc_plus4` into register `link_idx` |
| link_idx | output | 5 | Register number for the exception link write (27) |

## Verification
All state in the block sits in the PC register. A wrong next-address choice or a bad target computation therefore shows on `pc` exactly one edge after the cycle that caused it. `pc_plus4` and `link_we` show faults in the same cycle. Every stimulus cycle is checked against an independent model for both variants at once, so a fault shows up at the first step where the variants or the sources differ. The chosen corner cases have distinct expected values: backward branches, a jump from just below a region boundary, a sequential step across that boundary, misaligned register targets, and simultaneous reset, interrupt and illegal opcode.

// File: rtl/fau_pkg.sv
package fau_pkg;
   typedef enum logic [1:0] {
      SRC_SEQ    = 2'b00,
      SRC_BRANCH = 2'b01,
      SRC_JUMP   = 2'b10,
      SRC_REG    = 2'b11
   } next_src_e;
endpackage

// File: rtl/fau_incr.sv
module fau_incr #(
   parameter int W = 32,
   parameter int STEP = 4
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);
   assign y = a + W'(STEP);
endmodule

// File: rtl/fau_branch_tgt.sv
module fau_branch_tgt #(
   parameter int W = 32,
   parameter int OFS_W = 16
) (
   input  logic [W-1:0]     base,
   input  logic [OFS_W-1:0] ofs,
   output logic [W-1:0]     tgt
);
   localparam int EXT_W = W - OFS_W - 2;
   logic [W-1:0] ofs_bytes;
   assign ofs_bytes = {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
   assign tgt = base + ofs_bytes;
endmodule

// File: rtl/fau_jump_tgt.sv
module fau_jump_tgt #(
   parameter int W = 32,
   parameter int IDX_W = 26
) (
   input  logic [W-1:0]     cur,
   input  logic [IDX_W-1:0] idx,
   output logic [W-1:0]     tgt
);
   localparam int REGION_W = W - IDX_W - 2;
   assign tgt = {cur[W-1 -: REGION_W], idx, 2'b00};
endmodule

// File: rtl/fau_next_sel.sv
module fau_next_sel
   import fau_pkg::*;
#(
   parameter int          W        = 32,
   parameter bit          EXT_MODE = 1'b1,
   parameter logic [31:0] BADOP_VEC = 32'h8000_0040,
   parameter logic [31:0] IRQ_VEC   = 32'h8000_0080
) (
   input  logic [1:0]   sel,
   input  logic [W-1:0] seq_a,
   input  logic [W-1:0] br_a,
   input  logic [W-1:0] jmp_a,
   input  logic [W-1:0] reg_a,
   input  logic         irq,
   input  logic         bad_op,
   output logic [W-1:0] nxt,
   output logic         exc_take
);
   logic [W-1:0] norm_a;

   always_comb begin
      unique case (next_src_e'(sel))
         SRC_SEQ:    norm_a = seq_a;
         SRC_BRANCH: norm_a = br_a;
         SRC_JUMP:   norm_a = jmp_a;
         default:    norm_a = {reg_a[W-1:2], 2'b00};
      endcase
   end

   generate
      if (EXT_MODE) begin : g_ext
         always_comb begin
            exc_take = irq | bad_op;
            if (irq)         nxt = W'(IRQ_VEC);
            else if (bad_op) nxt = W'(BADOP_VEC);
            else             nxt = norm_a;
         end
      end else begin : g_basic
         logic unused_exc;
         assign unused_exc = irq ^ bad_op;
         assign exc_take   = 1'b0;
         assign nxt        = norm_a;
      end
   endgenerate
endmodule

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit #(
   parameter int          ADDR_W     = 32,
   parameter int          OFS_W      = 16,
   parameter int          IDX_W      = 26,
   parameter int          RIDX_W     = 5,
   parameter int          LINK_REG   = 27,
   parameter bit          EXT_MODE   = 1'b1,
   parameter logic [31:0] BOOT_VEC   = 32'h8000_0000,
   parameter logic [31:0] BADOP_VEC  = 32'h8000_0040,
   parameter logic [31:0] IRQ_VEC    = 32'h8000_0080
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [31:0]       instr,
   input  logic [1:0]        pc_sel,
   input  logic [ADDR_W-1:0] reg_target,
   input  logic              irq,
   input  logic              bad_op,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] pc_plus4,
   output logic              link_we,
   output logic [RIDX_W-1:0] link_idx
);
   localparam logic [ADDR_W-1:0] RST_VEC = EXT_MODE ? ADDR_W'(BOOT_VEC) : '0;

   initial begin
      assert (ADDR_W > IDX_W + 2) else $fatal(1, "jump index does not fit the address");
      assert (ADDR_W >= OFS_W + 2) else $fatal(1, "branch offset wider than address");
      assert (LINK_REG < (1 << RIDX_W)) else $fatal(1, "link register out of range");
      assert ((BOOT_VEC[1:0] | BADOP_VEC[1:0] | IRQ_VEC[1:0]) == 2'b00)
         else $fatal(1, "vectors must be word aligned");
   end

   logic [ADDR_W-1:0] br_a, jmp_a, nxt;
   logic              exc_take;
   logic [31:0]       unused_instr;

   assign unused_instr = instr;

   fau_incr #(.W(ADDR_W), .STEP(4)) u_incr (
      .a(pc), .y(pc_plus4)
   );

   fau_branch_tgt #(.W(ADDR_W), .OFS_W(OFS_W)) u_br (
      .base(pc_plus4), .ofs(instr[OFS_W-1:0]), .tgt(br_a)
   );

   fau_jump_tgt #(.W(ADDR_W), .IDX_W(IDX_W)) u_jmp (
      .cur(pc), .idx(instr[IDX_W-1:0]), .tgt(jmp_a)
   );

   fau_next_sel #(
      .W(ADDR_W), .EXT_MODE(EXT_MODE),
      .BADOP_VEC(BADOP_VEC), .IRQ_VEC(IRQ_VEC)
   ) u_sel (
      .sel(pc_sel), .seq_a(pc_plus4), .br_a(br_a), .jmp_a(jmp_a),
      .reg_a(reg_target), .irq(irq), .bad_op(bad_op),
      .nxt(nxt), .exc_take(exc_take)
   );

   always_ff @(posedge clk) begin
      if (rst) pc <= RST_VEC;
      else     pc <= nxt;
   end

   assign link_we  = exc_take & ~rst;
   assign link_idx = RIDX_W'(LINK_REG);
endmodule

// File: rtl/fau_checks.sv
module fau_checks #(
   parameter int          ADDR_W   = 32,
   parameter int          IDX_W    = 26,
   parameter bit          EXT_MODE = 1'b1,
   parameter logic [31:0] BOOT_VEC = 32'h8000_0000,
   parameter logic [31:0] IRQ_VEC  = 32'h8000_0080
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        pc_sel,
   input logic              irq,
   input logic              bad_op,
   input logic [ADDR_W-1:0] pc,
   input logic              link_we
);
   localparam int REGION_W = ADDR_W - IDX_W - 2;
   localparam logic [ADDR_W-1:0] RST_VEC = EXT_MODE ? ADDR_W'(BOOT_VEC) : '0;

   logic exc_in;
   assign exc_in = EXT_MODE && (irq || bad_op);

   AST_RESET_VEC: assert property (@(posedge clk)
      rst |=> pc == RST_VEC) else $error("reset vector");   // R1

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
      (pc_sel == 2'b00 && !exc_in) |=> pc == $past(pc) + ADDR_W'(4))
      else $error("sequential step");   // R2

   AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
      (pc_sel == 2'b10 && !exc_in) |=> pc[ADDR_W-1 -: REGION_W] == $past(pc[ADDR_W-1 -: REGION_W]))
      else $error("jump region");   // R5

   AST_IRQ_VEC: assert property (@(posedge clk) disable iff (rst)
      (EXT_MODE && irq) |=> pc == ADDR_W'(IRQ_VEC)) else $error("irq vector");   // R8

   AST_LINK_SRC: assert property (@(posedge clk)
      link_we |-> (EXT_MODE && !rst && (irq || bad_op))) else $error("link source");   // R10

   AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00) else $error("pc alignment");   // R11
endmodule

bind fetch_addr_unit fau_checks #(
   .ADDR_W(ADDR_W), .IDX_W(IDX_W), .EXT_MODE(EXT_MODE),
   .BOOT_VEC(BOOT_VEC), .IRQ_VEC(IRQ_VEC)
) u_checks (
   .clk(clk), .rst(rst), .pc_sel(pc_sel), .irq(irq), .bad_op(bad_op),
   .pc(pc), .link_we(link_we)
);

// File: tb/fetch_addr_unit_test.sv
module fetch_addr_unit_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   logic [1:0]  pc_sel = 2'b00;
   logic [31:0] reg_target = '0;
   logic        irq = 1'b0, bad_op = 1'b0;
   logic [31:0] pc_x, pc4_x, pc_b, pc4_b;
   logic        lwe_x, lwe_b;
   logic [4:0]  lidx_x, lidx_b;

   int n_checks = 0, n_fail = 0;
   logic [31:0] exp_x = 32'h8000_0000, exp_b = 32'h0;

   always #2 clk = ~clk;

   fetch_addr_unit #(.EXT_MODE(1'b1)) uut (
      .clk(clk), .rst(rst), .instr(instr), .pc_sel(pc_sel), .reg_target(reg_target),
      .irq(irq), .bad_op(bad_op), .pc(pc_x), .pc_plus4(pc4_x),
      .link_we(lwe_x), .link_idx(lidx_x)
   );

   fetch_addr_unit #(.EXT_MODE(1'b0)) uut_basic (
      .clk(clk), .rst(rst), .instr(instr), .pc_sel(pc_sel), .reg_target(reg_target),
      .irq(irq), .bad_op(bad_op), .pc(pc_b), .pc_plus4(pc4_b),
      .link_we(lwe_b), .link_idx(lidx_b)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model(input logic [31:0] p, input bit ext,
                                         input logic [1:0] s, input logic [31:0] ins,
                                         input logic [31:0] rv, input logic ir,
                                         input logic bo, input logic rs);
      if (rs) return ext ? 32'h8000_0000 : 32'h0;
      if (ext && ir) return 32'h8000_0080;
      if (ext && bo) return 32'h8000_0040;
      case (s)
         2'b00:   return p + 32'd4;
         2'b01:   return p + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
         2'b10:   return {p[31:28], ins[25:0], 2'b00};
         default: return {rv[31:2], 2'b00};
      endcase
   endfunction

   task automatic step(input string req, input logic [1:0] s, input logic [31:0] ins,
                       input logic [31:0] rv, input logic ir, input logic bo, input logic rs);
      @(negedge clk);
      pc_sel = s; instr = ins; reg_target = rv; irq = ir; bad_op = bo; rst = rs;
      #1;
      check({req, " R3 pc_plus4"}, pc4_x, exp_x + 32'd4);
      check({req, " R9/R7 link_we ext"}, {31'd0, lwe_x}, {31'd0, !rs && (ir || bo)});
      check({req, " R10 link_we basic"}, {31'd0, lwe_b}, 32'd0);
      exp_x = model(exp_x, 1'b1, s, ins, rv, ir, bo, rs);
      exp_b = model(exp_b, 1'b0, s, ins, rv, ir, bo, rs);
      @(posedge clk); #1;
      check({req, " pc ext"}, pc_x, exp_x);
      check({req, " pc basic"}, pc_b, exp_b);
      check({req, " R11 alignment"}, {30'd0, pc_x[1:0] | pc_b[1:0]}, 32'd0);
   endtask

   task automatic t_reset();
      step("R1/R9 reset with irq+bad_op", 2'b10, 32'h03FF_FFFF, '0, 1'b1, 1'b1, 1'b1);
      check("R1 ext reset vector", pc_x, 32'h8000_0000);
      check("R1 basic reset vector", pc_b, 32'h0);
      check("R7 link index", {27'd0, lidx_x}, 32'd27);
   endtask

   task automatic t_seq();
      for (int i = 0; i < 3; i++) step("R2 sequential", 2'b00, 32'hFFFF_FFFF, '0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_branch();
      step("R6 reg target low bits forced", 2'b11, '0, 32'h0000_1003, 1'b0, 1'b0, 1'b0);
      check("R6 reg target value", pc_x, 32'h0000_1000);
      step("R4 branch negative", 2'b01, 32'h1234_FFFC, '0, 1'b0, 1'b0, 1'b0);
      check("R4 backward target", pc_x, 32'h0000_0FF4);
      step("R2 untaken branch", 2'b00, 32'h1234_FFFC, '0, 1'b0, 1'b0, 1'b0);
      step("R4 branch positive", 2'b01, 32'h0000_0010, '0, 1'b0, 1'b0, 1'b0);
      check("R4 forward target", pc_x, 32'h0000_103C);
      step("R4 branch most negative", 2'b01, 32'h0000_8000, '0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_jump();
      step("R6 reg target near region edge", 2'b11, '0, 32'h7FFF_FFF2, 1'b0, 1'b0, 1'b0);
      step("R5 jump keeps region", 2'b10, 32'hFFFF_FFFF, '0, 1'b0, 1'b0, 1'b0);
      check("R5 jump target", pc_x, 32'h7FFF_FFFC);
      step("R2 seq across region", 2'b00, '0, '0, 1'b0, 1'b0, 1'b0);
      check("R2 crossed boundary", pc_x, 32'h8000_0000);
      step("R5 jump in new region", 2'b10, 32'h0000_0010, '0, 1'b0, 1'b0, 1'b0);
      check("R5 new region target", pc_x, 32'h8000_0040);
   endtask

   task automatic t_exc();
      step("R6 reg to low address", 2'b11, '0, 32'h0000_2000, 1'b0, 1'b0, 1'b0);
      step("R7 bad opcode", 2'b00, '0, '0, 1'b0, 1'b1, 1'b0);
      check("R7 bad opcode vector", pc_x, 32'h8000_0040);
      check("R10 basic ignores bad_op", pc_b, 32'h0000_2004);
      step("R8 irq over bad_op", 2'b01, 32'h0000_0100, '0, 1'b1, 1'b1, 1'b0);
      check("R8 irq vector", pc_x, 32'h8000_0080);
      step("R8 irq over jump", 2'b10, 32'h0000_0001, '0, 1'b1, 1'b0, 1'b0);
      step("R10 basic irq with reg", 2'b11, '0, 32'h0000_3000, 1'b1, 1'b0, 1'b0);
      check("R10 basic follows select", pc_b, 32'h0000_3000);
      step("R1 reset again", 2'b00, '0, '0, 1'b0, 1'b1, 1'b1);
      step("R2 after reset", 2'b00, '0, '0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #(4 * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_seq();
      t_branch();
      t_jump();
      t_exc();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule